// File: doc/BRIEF.md
# Configuration Space Access Port

This block owns a small legacy configuration space that is reached through a pair of byte ports: offset 0 selects a register index and offset 1 moves data to or from the selected register. Access is closed after reset. Software opens it by writing a two-byte key to the index port and closes it again with a one-byte exit key. While access is closed, reads return all ones and data writes change nothing.

Once access is open, the space provides the following registers:

- A read-only 16-bit chip identifier.
- A read-only 16-bit manufacturer identifier.
- A device-select register that picks one of several logical devices.
- A 16-bit I/O base address for each logical device. Each device keeps its own copy, and the copy visible at the base-address indices is the one the device-select register points to.

The base address of the hardware-monitor device is also driven out continuously, so that the neighbouring decoder can claim its I/O window.

The read data is combinational from the registered state and from `acc_off`. Writes take effect on the rising clock edge on which `acc_en` and `acc_wr` are both high.

Top module: `sio_cfg_port`

## Requirements
- R1: On reset, access is closed, the index register is 0x00 and the device select is 0. Logical device n holds base address BASE_DFLT + n*BASE_STEP. With the defaults this is 0x0290 + n*0x10, so `hwm_base` reads 0x02D0 for device 4.
- R2: While access is closed, two index-port writes (`acc_off`=0) of 0x87 in a row open it. An index-port write of any other value between them restarts the key. Data-port accesses do not disturb the key.
- R3: While access is open, an index-port write of 0xAA closes it from the next cycle.
- R4: While access is closed, `acc_rdata` is 0xFF at both offsets. Index and data writes other than key bytes change no register, including the index, the device select and every base address.
- R5: While access is open, an index-port write of any value other than 0xAA is stored as the index, and offset 0 reads it back. This includes 0x87, which does nothing else while access is open.
- R6: Index 0x20 reads the high byte of CHIP_ID (default 0x0541) and 0x21 reads its low byte. Index 0x23 reads 0x19 and 0x24 reads 0x34. Writes to these indices are ignored.
- R7: Index 0x07 is the device select. A write keeps the low LDN_W bits (3 by default, so 0xFC selects 4), and a read returns the select zero-extended.
- R8: Index 0x60 is the high byte and 0x61 the low byte of the selected device's base address. A write changes only that device's copy.
- R9: `hwm_base` always shows the base address of device HWM_LDN (default 4), starting from the cycle after a write to it.
- R10: While access is open, any other index reads 0x00 and ignores data writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 1 | 0 = index port, 1 = data port |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte for the offset on `acc_off` |
| cfg_open | output | 1 | Configuration access is open |
| hwm_base | output | 16 | Base address of the hardware-monitor device |

## Verification
A wrong key state shows in the same cycle as 0xFF read data, or as valid data where 0xFF is expected. It also shows as a wrong `cfg_open` one cycle after the key byte. A corrupted index or device select shows on the very next data-port read. A write that lands in the wrong device's bank stays hidden until that device is selected, unless it is device 4, in which case `hwm_base` moves one cycle later. For this reason the bench compares every output against its model on every clock and reads other devices back after switching the select.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    typedef enum logic [1:0] {
        KEY_LOCKED = 2'd0,
        KEY_HALF   = 2'd1,
        KEY_OPEN   = 2'd2
    } key_state_e;

    localparam logic [7:0] KEY_ENTER   = 8'h87;
    localparam logic [7:0] KEY_EXIT    = 8'hAA;
    localparam logic [7:0] IDX_DEVSEL  = 8'h07;
    localparam logic [7:0] IDX_CHIP_HI = 8'h20;
    localparam logic [7:0] IDX_CHIP_LO = 8'h21;
    localparam logic [7:0] IDX_MFG_HI  = 8'h23;
    localparam logic [7:0] IDX_MFG_LO  = 8'h24;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;
    localparam logic [7:0] RD_CLOSED   = 8'hFF;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       open_o
);
    key_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            case (state_q)
                KEY_LOCKED: state_d = (wdata == KEY_ENTER) ? KEY_HALF : KEY_LOCKED;
                KEY_HALF:   state_d = (wdata == KEY_ENTER) ? KEY_OPEN : KEY_LOCKED;
                KEY_OPEN:   state_d = (wdata == KEY_EXIT)  ? KEY_LOCKED : KEY_OPEN;
                default:    state_d = KEY_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_LOCKED;
        else        state_q <= state_d;
    end

    assign open_o = (state_q == KEY_OPEN);

    // R2
    enter_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KEY_HALF && idx_wr && wdata == KEY_ENTER) |=> open_o);

    // R3
    exit_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && idx_wr && wdata == KEY_EXIT) |=> (state_q == KEY_LOCKED));
endmodule

// File: rtl/sio_base_bank.sv
module sio_base_bank #(
    parameter int          NUM_LDEV  = 8,
    parameter int          LDN_W     = 3,
    parameter int          HWM_LDN   = 4,
    parameter logic [15:0] BASE_DFLT = 16'h0290,
    parameter logic [15:0] BASE_STEP = 16'h0010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LDN_W-1:0] sel,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [7:0]       wdata,
    output logic [15:0]      sel_base,
    output logic [15:0]      hwm_base
);
    logic [15:0] bar_d [NUM_LDEV];
    logic [15:0] bar_q [NUM_LDEV];

    always_comb begin
        bar_d = bar_q;
        if (wr_hi) bar_d[sel][15:8] = wdata;
        if (wr_lo) bar_d[sel][7:0]  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LDEV; i++)
                bar_q[i] <= BASE_DFLT + 16'(i) * BASE_STEP;
        end else begin
            bar_q <= bar_d;
        end
    end

    assign sel_base = bar_q[sel];
    assign hwm_base = bar_q[HWM_LDN];

    for (genvar g = 0; g < NUM_LDEV; g++) begin : g_dev
        // R8
        other_dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((wr_hi || wr_lo) && sel != LDN_W'(g)) |=> $stable(bar_q[g]));
    end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] CHIP_ID   = 16'h0541,
    parameter logic [15:0] MFG_ID    = 16'h1934,
    parameter int          NUM_LDEV  = 8,
    parameter int          HWM_LDN   = 4,
    parameter logic [15:0] BASE_DFLT = 16'h0290,
    parameter logic [15:0] BASE_STEP = 16'h0010
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_en,
    input  logic        acc_wr,
    input  logic        acc_off,
    input  logic [7:0]  acc_wdata,
    output logic [7:0]  acc_rdata,
    output logic        cfg_open,
    output logic [15:0] hwm_base
);
    localparam int LDN_W = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;

    typedef struct packed {
        logic [7:0]       idx;
        logic [LDN_W-1:0] ldn;
    } cfg_regs_t;

    cfg_regs_t   regs_d, regs_q;
    logic        idx_wr, dat_wr;
    logic        bar_wr_hi, bar_wr_lo;
    logic [15:0] sel_base;

    assign idx_wr = acc_en && acc_wr && !acc_off;
    assign dat_wr = acc_en && acc_wr && acc_off && cfg_open;

    sio_key_fsm u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (idx_wr),
        .wdata  (acc_wdata),
        .open_o (cfg_open)
    );

    always_comb begin
        regs_d    = regs_q;
        bar_wr_hi = 1'b0;
        bar_wr_lo = 1'b0;
        if (cfg_open && idx_wr && acc_wdata != KEY_EXIT)
            regs_d.idx = acc_wdata;
        if (dat_wr) begin
            case (regs_q.idx)
                IDX_DEVSEL:  regs_d.ldn = acc_wdata[LDN_W-1:0];
                IDX_BASE_HI: bar_wr_hi  = 1'b1;
                IDX_BASE_LO: bar_wr_lo  = 1'b1;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    sio_base_bank #(
        .NUM_LDEV  (NUM_LDEV),
        .LDN_W     (LDN_W),
        .HWM_LDN   (HWM_LDN),
        .BASE_DFLT (BASE_DFLT),
        .BASE_STEP (BASE_STEP)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (regs_q.ldn),
        .wr_hi    (bar_wr_hi),
        .wr_lo    (bar_wr_lo),
        .wdata    (acc_wdata),
        .sel_base (sel_base),
        .hwm_base (hwm_base)
    );

    always_comb begin
        if (!cfg_open) begin
            acc_rdata = RD_CLOSED;
        end else if (!acc_off) begin
            acc_rdata = regs_q.idx;
        end else begin
            case (regs_q.idx)
                IDX_DEVSEL:  acc_rdata = 8'(regs_q.ldn);
                IDX_CHIP_HI: acc_rdata = CHIP_ID[15:8];
                IDX_CHIP_LO: acc_rdata = CHIP_ID[7:0];
                IDX_MFG_HI:  acc_rdata = MFG_ID[15:8];
                IDX_MFG_LO:  acc_rdata = MFG_ID[7:0];
                IDX_BASE_HI: acc_rdata = sel_base[15:8];
                IDX_BASE_LO: acc_rdata = sel_base[7:0];
                default:     acc_rdata = 8'h00;
            endcase
        end
    end

    // R4
    closed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && acc_en && acc_wr && acc_off) |=> ($stable(hwm_base) && $stable(regs_q)));

    // R2
    open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(idx_wr && acc_wdata == KEY_ENTER));
endmodule

// File: tb/tb_sio_cfg_port.sv
module tb_sio_cfg_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0, acc_wr = 1'b0, acc_off = 1'b0;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] acc_rdata;
    logic       cfg_open;
    logic [15:0] hwm_base;

    int tests = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sio_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_off(acc_off), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .cfg_open(cfg_open), .hwm_base(hwm_base)
    );

    // behavioural reference: 0 closed, 1 half key, 2 open
    int          m_key = 0;
    int          m_idx = 0;
    int          m_ldn = 0;
    int          m_bar [8];

    task automatic model_reset();
        m_key = 0; m_idx = 0; m_ldn = 0;
        for (int n = 0; n < 8; n++) m_bar[n] = 'h290 + n * 'h10;
    endtask

    initial model_reset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else if (acc_en && acc_wr) begin
            if (!acc_off) begin
                if (m_key == 2) begin
                    if (acc_wdata == 8'hAA) m_key = 0;
                    else m_idx = acc_wdata;
                end else if (acc_wdata == 8'h87) m_key = m_key + 1;
                else m_key = 0;
            end else if (m_key == 2) begin
                if (m_idx == 'h07) m_ldn = acc_wdata % 8;
                else if (m_idx == 'h60) m_bar[m_ldn] = (m_bar[m_ldn] % 256) + acc_wdata * 256;
                else if (m_idx == 'h61) m_bar[m_ldn] = (m_bar[m_ldn] / 256) * 256 + acc_wdata;
            end
        end
    end

    function automatic int model_read(input logic off);
        if (m_key != 2) return 'hFF;
        if (!off) return m_idx;
        case (m_idx)
            'h07: return m_ldn;
            'h20: return 'h05;
            'h21: return 'h41;
            'h23: return 'h19;
            'h24: return 'h34;
            'h60: return m_bar[m_ldn] / 256;
            'h61: return m_bar[m_ldn] % 256;
            default: return 0;
        endcase
    endfunction

    function automatic string read_tag(input logic off);
        if (m_key != 2) return "R4";
        if (!off) return "R5";
        case (m_idx)
            'h07: return "R7";
            'h20, 'h21, 'h23, 'h24: return "R6";
            'h60, 'h61: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            check(int'(acc_rdata), model_read(acc_off), read_tag(acc_off));
            check(int'(cfg_open), int'(m_key == 2), "R2_R3_open");
            check(int'(hwm_base), m_bar[4], "R9");
        end
    end

    task automatic wr(input logic off, input logic [7:0] d);
        @(negedge clk);
        acc_en = 1; acc_wr = 1; acc_off = off; acc_wdata = d;
    endtask

    task automatic rd(input logic off, input logic [7:0] exp, input string tag);
        @(negedge clk);
        acc_en = 0; acc_wr = 0; acc_off = off;
        #3 check(int'(acc_rdata), int'(exp), tag);
    endtask

    task automatic idle();
        @(negedge clk);
        acc_en = 0; acc_wr = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        rd(1, 8'hFF, "R1");
        check(int'(cfg_open), 0, "R1");
        check(int'(hwm_base), 'h02D0, "R1");

        wr(1, 8'h12);
        rd(1, 8'hFF, "R4");
        rd(0, 8'hFF, "R4");

        wr(0, 8'h87); wr(0, 8'h55); wr(0, 8'h87);
        idle();
        check(int'(cfg_open), 0, "R2");
        wr(0, 8'h87);
        idle();
        check(int'(cfg_open), 1, "R2");
        wr(0, 8'hAA);
        wr(0, 8'h87); wr(1, 8'h00); wr(0, 8'h87);
        idle();
        check(int'(cfg_open), 1, "R2");

        wr(0, 8'h20); rd(0, 8'h20, "R5"); rd(1, 8'h05, "R6");
        wr(0, 8'h21); rd(1, 8'h41, "R6");
        wr(0, 8'h23); rd(1, 8'h19, "R6");
        wr(0, 8'h24); rd(1, 8'h34, "R6");
        wr(1, 8'h00); rd(1, 8'h34, "R6");

        wr(0, 8'h07); rd(1, 8'h00, "R7");
        wr(0, 8'h60); rd(1, 8'h02, "R8");
        wr(0, 8'h07); wr(1, 8'h04);
        wr(0, 8'h60); wr(1, 8'h0A);
        wr(0, 8'h61); wr(1, 8'h35);
        idle();
        check(int'(hwm_base), 'h0A35, "R9");
        wr(0, 8'h07); wr(1, 8'h02);
        wr(0, 8'h60); rd(1, 8'h02, "R8");
        wr(0, 8'h61); rd(1, 8'hB0, "R8");
        wr(1, 8'h77); rd(1, 8'h77, "R8");
        check(int'(hwm_base), 'h0A35, "R8");

        wr(0, 8'h07); wr(1, 8'hFC); rd(1, 8'h04, "R7");
        wr(0, 8'h60); rd(1, 8'h0A, "R8");

        wr(0, 8'h55); rd(1, 8'h00, "R10");
        wr(1, 8'h99); rd(1, 8'h00, "R10");
        wr(0, 8'h87); rd(0, 8'h87, "R5");
        check(int'(cfg_open), 1, "R5");

        wr(0, 8'hAA);
        idle();
        check(int'(cfg_open), 0, "R3");
        rd(0, 8'hFF, "R4");
        wr(0, 8'h07); wr(1, 8'h01); wr(0, 8'h61); wr(1, 8'h00);
        wr(0, 8'h87); wr(0, 8'h87);
        rd(0, 8'h87, "R4");
        wr(0, 8'h07); rd(1, 8'h04, "R4");
        check(int'(hwm_base), 'h0A35, "R4");

        @(negedge clk) rst_n = 0; acc_en = 0; acc_wr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        idle();
        check(int'(cfg_open), 0, "R1");
        check(int'(hwm_base), 'h02D0, "R1");
        wr(0, 8'h87); wr(0, 8'h87);
        rd(0, 8'h00, "R1");
        wr(0, 8'h07); rd(1, 8'h00, "R1");
        wr(0, 8'h61); rd(1, 8'h90, "R1");
        idle();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule